// File: doc/BRIEF.md
# Scanline Draw Pass Controller

This block runs one drawing pass into a single scanline buffer of a tile-and-sprite video engine. A pass starts on a restart pulse. At that moment the block latches its configuration: layer mode bits, a sprite index range and a horizontal clip window. A tile walker then steps across every column of the line. At the same time, a sprite scanner walks the selected index range and queues each sprite that lies on the line into a small FIFO. Once the tile walker has finished, a sprite drawer takes queued sprites off the FIFO and writes their pixels. Transparent pixels and pixels outside the window are never written. A draw-done output rises when both layers are complete.

Several passes can be composed into the same buffer before it is shown. Each pass can use its own sprite range, clip span and layer selection. Columns that a pass does not write keep what earlier passes left there. The display side reads the buffer through a readout port. Each column that is read is replaced by the background colour, so the buffer is clean for the next line without any overdraw pass.

The image sources are fixed arithmetic stubs, defined in the requirements below, that stand in for pattern memories.

Top module: `scanline_pass_ctrl`

## Requirements
- R1: After reset, draw_done is 1 and every buffer column reads back as 0.
- R2: In the cycle after a restart pulse, draw_done is 0. It returns to 1 once both layers of the new pass have finished, and it stays at 1 until the next restart. A restart during a pass abandons that pass and begins again from the first column and the base sprite.
- R3: Mode bit 0 set means no sprite pixel is written. Mode bit 1 set means no tile pixel is written. With mode 3, or with both window bounds at a column beyond the line width, the pass writes nothing.
- R4: The tile pixel at column x has the value (x + scroll) mod 256. It is transparent, and therefore not written, when its two low bits are 00.
- R5: The sprite walk starts at the 16-bit base index. It keeps the high byte fixed and increments the low byte with wrap from 255 to 0. It stops after the sprite whose low byte equals the 8-bit end value. This covers 1 to 256 sprites. Sprites are drawn in walk order, so a later sprite overwrites an earlier one.
- R6: A sprite with index i lies on the line unless i[1:0] = 11. It covers the 4 columns (i[7:0]*5 mod 256) + k, for k = 0..3. Pixel k has the colour {1, XOR of i[15:8], i[3:0], k[1:0]}. Pixel k = 3 is transparent when i[0] = 1.
- R7: Mode bit 2 clear: sprite pixels overwrite tile pixels. Mode bit 2 set: a sprite pixel is written only in columns where this pass has not written an opaque tile pixel.
- R8: A pixel is written only when X0 <= x <= X1 and x < LINE_W. When X1 < X0, nothing is written.
- R9: A read with rd_en at rd_addr presents that column's content on rd_data one cycle later. The column then holds bg_color.
- R10: When a draw write and a readout hit the same column in the same cycle, the readout returns the old content and the draw write is the value that stays in the buffer.
- R11: Columns that a pass leaves unwritten (transparent, clipped or disabled) keep their previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Pulse: latch the configuration and begin a new pass |
| mode | input | 3 | bit0 sprites off, bit1 tiles off, bit2 sprites behind tiles |
| spr_base | input | 16 | First sprite index; high byte is the page |
| spr_end | input | 8 | Low byte of the last sprite index |
| win_x0 | input | 16 | Left clip bound, inclusive |
| win_x1 | input | 16 | Right clip bound, inclusive |
| tile_scroll | input | 8 | Offset added to the column by the tile stub |
| bg_color | input | 8 | Colour written into a column as it is read out |
| rd_en | input | 1 | Readout strobe |
| rd_addr | input | $clog2(LINE_W) | Readout column |
| rd_data | output | 8 | Column content, one cycle after the strobe |
| draw_done | output | 1 | Both layers of the current pass are finished |

## Verification
A readout that clears a column to the background can land in the same cycle as a draw write to that column. The bench provokes this by holding the readout strobe on one opaque tile column for the whole of a tile pass. The write must win that cycle: the tile value must appear on rd_data exactly once, and because the readout continues, the column must end up holding the background.

// File: rtl/scanpass_pkg.sv
package scanpass_pkg;

    localparam int PIX_W = 8;
    localparam int IDX_W = 16;
    localparam int POS_W = 16;

    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic       behind;
        logic       tile_off;
        logic       spr_off;
    } mode_t;

    typedef struct packed {
        mode_t      mode;
        idx_t       base;
        logic [7:0] last;
        pos_t       x0;
        pos_t       x1;
        logic [7:0] scroll;
    } pass_cfg_t;

    function automatic pix_t tile_pix(input logic [7:0] x, input logic [7:0] scroll);
        return x + scroll;
    endfunction

    function automatic logic tile_opaque(input pix_t p);
        return p[1:0] != 2'b00;
    endfunction

    function automatic logic spr_on_line(input idx_t i);
        return i[1:0] != 2'b11;
    endfunction

    function automatic pos_t spr_col_x(input idx_t i, input logic [1:0] k);
        logic [7:0] org;
        org = i[7:0] * 8'd5;
        return {8'h00, org} + {14'b0, k};
    endfunction

    function automatic pix_t spr_pix(input idx_t i, input logic [1:0] k);
        return {1'b1, ^i[15:8], i[3:0], k};
    endfunction

    function automatic logic spr_opaque(input idx_t i, input logic [1:0] k);
        return !(k == 2'd3 && i[0]);
    endfunction

endpackage

// File: rtl/scanpass_tile_walk.sv
module scanpass_tile_walk
    import scanpass_pkg::*;
#(
    parameter int LINE_W = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tile_off,
    input  logic [7:0] scroll,
    output logic       px_vld,
    output pos_t       px_x,
    output pix_t       px_col,
    output logic       done
);
    localparam int XW = $clog2(LINE_W);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [XW-1:0] x;
    } walk_t;

    walk_t st_d, st_q;
    logic [7:0] x8;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = !tile_off;
            st_d.done = tile_off;
            st_d.x    = '0;
        end else if (st_q.busy) begin
            if (st_q.x == XW'(LINE_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b1, x: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign x8     = 8'(st_q.x);
    assign px_col = tile_pix(x8, scroll);
    assign px_vld = st_q.busy && tile_opaque(px_col);
    assign px_x   = POS_W'(st_q.x);
    assign done   = st_q.done;

endmodule

// File: rtl/scanpass_idx_fifo.sv
module scanpass_idx_fifo
    import scanpass_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  idx_t din,
    input  logic pop,
    output idx_t dout,
    output logic empty,
    output logic full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] mem;
        logic [PW-1:0]               wp;
        logic [PW-1:0]               rp;
        logic [PW:0]                 cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = st_q.cnt == '0;
    assign full    = st_q.cnt == (PW + 1)'(DEPTH);
    assign dout    = st_q.mem[st_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp = nxt(st_q.wp);
            end
            if (do_pop) begin
                st_d.rp = nxt(st_q.rp);
            end
            if (do_push && !do_pop) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/scanpass_spr_scan.sv
module scanpass_spr_scan
    import scanpass_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       spr_off,
    input  idx_t       base,
    input  logic [7:0] last,
    input  logic       fifo_full,
    output logic       push,
    output idx_t       push_idx,
    output logic       done
);
    typedef struct packed {
        logic busy;
        logic done;
        idx_t idx;
    } scan_t;

    scan_t st_d, st_q;
    logic  step;

    assign step     = st_q.busy && !fifo_full;
    assign push     = step && spr_on_line(st_q.idx);
    assign push_idx = st_q.idx;
    assign done     = st_q.done;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = !spr_off;
            st_d.done = spr_off;
            st_d.idx  = base;
        end else if (step) begin
            if (st_q.idx[7:0] == last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = {st_q.idx[15:8], st_q.idx[7:0] + 8'd1};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b1, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/scanpass_spr_draw.sv
module scanpass_spr_draw
    import scanpass_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic go,
    input  logic scan_done,
    input  logic f_empty,
    input  idx_t f_dout,
    output logic pop,
    output logic px_vld,
    output pos_t px_x,
    output pix_t px_col,
    output logic done
);
    typedef struct packed {
        logic       active;
        idx_t       idx;
        logic [1:0] k;
    } draw_t;

    draw_t st_d, st_q;

    assign pop    = !st_q.active && go && !f_empty && !start;
    assign px_vld = st_q.active && spr_opaque(st_q.idx, st_q.k);
    assign px_x   = spr_col_x(st_q.idx, st_q.k);
    assign px_col = spr_pix(st_q.idx, st_q.k);
    assign done   = go && scan_done && f_empty && !st_q.active;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (st_q.k == 2'd3) begin
                st_d.active = 1'b0;
            end else begin
                st_d.k = st_q.k + 2'd1;
            end
        end else if (pop) begin
            st_d.active = 1'b1;
            st_d.idx    = f_dout;
            st_d.k      = 2'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/scanline_pass_ctrl.sv
module scanline_pass_ctrl
    import scanpass_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int FIFO_D = 8,
    localparam int XW    = $clog2(LINE_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [2:0]    mode,
    input  logic [15:0]   spr_base,
    input  logic [7:0]    spr_end,
    input  logic [15:0]   win_x0,
    input  logic [15:0]   win_x1,
    input  logic [7:0]    tile_scroll,
    input  logic [7:0]    bg_color,
    input  logic          rd_en,
    input  logic [XW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          draw_done
);
    typedef struct packed {
        pass_cfg_t                   cfg;
        logic                        start;
        logic [LINE_W-1:0]           cov;
        logic [LINE_W-1:0][PIX_W-1:0] lb;
        pix_t                        rd;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic t_vld, t_done, t_wr;
    pos_t t_x;
    pix_t t_col;
    logic s_vld, s_done, s_wr;
    pos_t s_x;
    pix_t s_col;
    logic sc_push, sc_done, f_pop, f_empty, f_full;
    idx_t sc_idx, f_dout;

    function automatic logic in_win(input pos_t x, input pass_cfg_t c);
        return (x >= c.x0) && (x <= c.x1) && (x < POS_W'(LINE_W));
    endfunction

    scanpass_tile_walk #(.LINE_W(LINE_W)) i_tile (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (st_q.start),
        .tile_off(st_q.cfg.mode.tile_off),
        .scroll  (st_q.cfg.scroll),
        .px_vld  (t_vld),
        .px_x    (t_x),
        .px_col  (t_col),
        .done    (t_done)
    );

    scanpass_spr_scan i_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (st_q.start),
        .spr_off  (st_q.cfg.mode.spr_off),
        .base     (st_q.cfg.base),
        .last     (st_q.cfg.last),
        .fifo_full(f_full),
        .push     (sc_push),
        .push_idx (sc_idx),
        .done     (sc_done)
    );

    scanpass_idx_fifo #(.DEPTH(FIFO_D)) i_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (st_q.start),
        .push (sc_push),
        .din  (sc_idx),
        .pop  (f_pop),
        .dout (f_dout),
        .empty(f_empty),
        .full (f_full)
    );

    scanpass_spr_draw i_draw (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (st_q.start),
        .go       (t_done),
        .scan_done(sc_done),
        .f_empty  (f_empty),
        .f_dout   (f_dout),
        .pop      (f_pop),
        .px_vld   (s_vld),
        .px_x     (s_x),
        .px_col   (s_col),
        .done     (s_done)
    );

    assign t_wr = t_vld && in_win(t_x, st_q.cfg);
    assign s_wr = s_vld && in_win(s_x, st_q.cfg)
                  && !(st_q.cfg.mode.behind && st_q.cov[s_x[XW-1:0]]);

    always_comb begin
        st_d = st_q;
        st_d.start = restart;
        if (restart) begin
            st_d.cfg = '{mode: mode_t'(mode), base: spr_base, last: spr_end,
                         x0: win_x0, x1: win_x1, scroll: tile_scroll};
        end
        if (st_q.start) begin
            st_d.cov = '0;
        end
        if (rd_en) begin
            st_d.rd          = st_q.lb[rd_addr];
            st_d.lb[rd_addr] = bg_color;
        end
        if (t_wr) begin
            st_d.lb[t_x[XW-1:0]]  = t_col;
            st_d.cov[t_x[XW-1:0]] = 1'b1;
        end
        if (s_wr) begin
            st_d.lb[s_x[XW-1:0]] = s_col;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.rd;
    assign draw_done = t_done && s_done && !st_q.start;

endmodule

// File: rtl/scanpass_chk.sv
module scanpass_chk (
    input logic clk,
    input logic rst_n,
    input logic restart,
    input logic draw_done,
    input logic start_q,
    input logic spr_off,
    input logic tile_off,
    input logic t_vld,
    input logic s_vld,
    input logic t_wr,
    input logic s_wr,
    input logic sc_push,
    input logic f_full
);
    a_r2_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !draw_done);

    a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (draw_done && !restart) |=> draw_done);

    a_r7_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({t_wr, s_wr}));

    a_r3_no_sprite_px: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_off && !start_q && !$past(start_q) && !$past(restart)) |-> !s_vld);

    a_r3_no_tile_px: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_off && !start_q && !$past(restart)) |-> !t_vld);

    a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        f_full |-> !sc_push);
endmodule

bind scanline_pass_ctrl scanpass_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .draw_done(draw_done),
    .start_q  (st_q.start),
    .spr_off  (st_q.cfg.mode.spr_off),
    .tile_off (st_q.cfg.mode.tile_off),
    .t_vld    (t_vld),
    .s_vld    (s_vld),
    .t_wr     (t_wr),
    .s_wr     (s_wr),
    .sc_push  (sc_push),
    .f_full   (f_full)
);

// File: tb/test_scanline_pass_ctrl.sv
module test_scanline_pass_ctrl;
    localparam int W = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] spr_base = 16'd0;
    logic [7:0]  spr_end = 8'd0;
    logic [15:0] win_x0 = 16'd0;
    logic [15:0] win_x1 = 16'd63;
    logic [7:0]  tile_scroll = 8'd0;
    logic [7:0]  bg_color = 8'd0;
    logic        rd_en = 1'b0;
    logic [5:0]  rd_addr = 6'd0;
    logic [7:0]  rd_data;
    logic        draw_done;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_lb [W];

    always #5 clk = ~clk;

    scanline_pass_ctrl #(.LINE_W(W), .FIFO_D(8)) i_scanline_pass_ctrl (
        .clk(clk), .rst_n(rst_n), .restart(restart), .mode(mode),
        .spr_base(spr_base), .spr_end(spr_end), .win_x0(win_x0), .win_x1(win_x1),
        .tile_scroll(tile_scroll), .bg_color(bg_color), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .draw_done(draw_done)
    );

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
        end
    endtask

    function automatic bit win_ok(input int x, input int x0, input int x1);
        return x >= x0 && x <= x1 && x < W;
    endfunction

    task automatic model_pass(input logic [2:0] m, input logic [15:0] b, input logic [7:0] e,
                              input int x0, input int x1, input logic [7:0] sc);
        bit cov [W];
        for (int x = 0; x < W; x++) cov[x] = 0;
        if (!m[1]) begin
            for (int x = 0; x < W; x++) begin
                logic [7:0] p;
                p = 8'(x) + sc;
                if (p[1:0] != 2'b00 && win_ok(x, x0, x1)) begin
                    exp_lb[x] = p;
                    cov[x] = 1;
                end
            end
        end
        if (!m[0]) begin
            logic [15:0] i;
            i = b;
            for (int n = 0; n < 256; n++) begin
                if (i[1:0] != 2'b11) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] org;
                        int x;
                        org = i[7:0] * 8'd5;
                        x = int'(org) + k;
                        if (!(k == 3 && i[0]) && win_ok(x, x0, x1) && !(m[2] && cov[x]))
                            exp_lb[x] = {1'b1, ^i[15:8], i[3:0], 2'(k)};
                    end
                end
                if (i[7:0] == e) break;
                i[7:0] = i[7:0] + 8'd1;
            end
        end
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!draw_done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, int'(draw_done), 1, "draw_done after pass");
    endtask

    task automatic run_pass(input string req, input logic [2:0] m, input logic [15:0] b,
                            input logic [7:0] e, input int x0, input int x1, input logic [7:0] sc);
        model_pass(m, b, e, x0, x1, sc);
        @(negedge clk);
        mode = m; spr_base = b; spr_end = e;
        win_x0 = 16'(x0); win_x1 = 16'(x1); tile_scroll = sc;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R2", int'(draw_done), 0, "draw_done right after restart");
        wait_done(req);
    endtask

    task automatic read_line(input string req);
        for (int a = 0; a < W; a++) begin
            @(negedge clk);
            rd_en = 1'b1;
            rd_addr = 6'(a);
            @(negedge clk);
            rd_en = 1'b0;
            chk(req, int'(rd_data), int'(exp_lb[a]), $sformatf("column %0d", a));
            exp_lb[a] = bg_color;
        end
    endtask

    task automatic t_reset;
        chk("R1", int'(draw_done), 1, "draw_done after reset");
        read_line("R1");
    endtask

    task automatic t_tiles;
        run_pass("R4", 3'd1, 16'h0000, 8'h00, 0, 63, 8'd3);
        read_line("R4");
    endtask

    task automatic t_sprites;
        run_pass("R6", 3'd2, 16'h0100, 8'h14, 0, 63, 8'd0);
        read_line("R6");
        run_pass("R5", 3'd2, 16'h0335, 8'h3E, 0, 63, 8'd0);
        read_line("R5");
    endtask

    task automatic t_order;
        run_pass("R7", 3'd0, 16'h0005, 8'h0C, 0, 63, 8'd1);
        read_line("R7");
        run_pass("R7", 3'd4, 16'h0005, 8'h0C, 0, 63, 8'd1);
        read_line("R7");
    endtask

    task automatic t_clip;
        run_pass("R8", 3'd0, 16'h0000, 8'h0A, 10, 40, 8'd2);
        read_line("R8");
        run_pass("R8", 3'd0, 16'h0000, 8'h0A, 30, 20, 8'd2);
        read_line("R8");
    endtask

    task automatic t_nodraw;
        bg_color = 8'h5A;
        run_pass("R3", 3'd0, 16'h0000, 8'h10, 0, 63, 8'd0);
        read_line("R9");
        read_line("R9");
        run_pass("R3", 3'd3, 16'h0000, 8'h10, 0, 63, 8'd0);
        read_line("R3");
        run_pass("R3", 3'd0, 16'h0000, 8'h10, 200, 200, 8'd0);
        read_line("R3");
    endtask

    task automatic t_accumulate;
        bg_color = 8'h11;
        run_pass("R11", 3'd2, 16'h0000, 8'h0C, 0, 63, 8'd0);
        run_pass("R11", 3'd1, 16'h0000, 8'h00, 0, 63, 8'd0);
        read_line("R11");
    endtask

    task automatic t_full_range;
        run_pass("R5", 3'd0, 16'h0210, 8'h0F, 0, 63, 8'd5);
        read_line("R5");
    endtask

    task automatic t_restart_mid;
        model_pass(3'd1, 16'h0000, 8'h00, 0, 63, 8'd7);
        @(negedge clk);
        mode = 3'd1; tile_scroll = 8'd7; win_x0 = 16'd0; win_x1 = 16'd63;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        repeat (20) @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R2", int'(draw_done), 0, "draw_done after mid-pass restart");
        wait_done("R2");
        read_line("R2");
    endtask

    task automatic t_collision;
        int seen;
        bg_color = 8'h33;
        seen = 0;
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = 6'd10;
        mode = 3'd1; tile_scroll = 8'd0; win_x0 = 16'd0; win_x1 = 16'd63;
        restart = 1'b1;
        model_pass(3'd1, 16'h0000, 8'h00, 0, 63, 8'd0);
        @(negedge clk);
        restart = 1'b0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (rd_data == 8'h0A) seen++;
        end
        rd_en = 1'b0;
        chk("R10", seen, 1, "times the written tile value was read out");
        exp_lb[10] = bg_color;
        read_line("R10");
    endtask

    initial begin
        for (int a = 0; a < W; a++) exp_lb[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tiles();
        t_sprites();
        t_order();
        t_clip();
        t_nodraw();
        t_accumulate();
        t_full_range();
        t_restart_mid();
        t_collision();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule